// File: doc/BRIEF.md
# Double-Precision Compare and Classify Unit

This block works on the raw bit patterns of two 64-bit IEEE-754 binary64 operands. An operation code picks one of four functions: a quiet less-than test, a signaling equality test, a NaN-aware maximum, or a ten-bit class mask of operand A. Every function also yields an invalid-operation flag, and each one follows its own rule for when that flag is raised.

The inputs come with a valid strobe. When the strobe is high, the result word and the flag are captured in registers, and a matching output valid appears one clock later. Boolean answers occupy bit 0 of the result word. The class mask is zero-extended into the result word. No rounding or arithmetic takes place. Signed zeros, infinities, subnormals and both kinds of NaN are resolved from the exponent and fraction fields alone.

Top module: `fpcc_unit`

## Requirements
- R1: Less-than (op code 0) gives 0 when either operand is a NaN. For this op the invalid flag is 1 only when at least one operand is a signaling NaN, and it is 0 for a quiet NaN or for no NaN.
- R2: Equality (op code 1) gives 0 and sets the invalid flag whenever either operand is a NaN of either kind.
- R3: Equality between two non-NaN operands is 1 when their bit patterns are identical, or when both have bits 62:0 clear, so +0 equals -0. It is 0 otherwise, with the flag clear.
- R4: For less-than between non-NaN operands whose sign bits (bit 63) differ, the result is 1 exactly when A is negative and at least one operand has a nonzero magnitude in bits 62:0.
- R5: For less-than between non-NaN operands with equal sign bits, the result is 1 exactly when the patterns differ and the sign bit XOR (A below B as unsigned 64-bit integers) is 1.
- R6: Maximum (op code 2) returns A when B is a NaN or when B is quietly less than A, and returns B otherwise. Its invalid flag is 1 only when an operand is a signaling NaN.
- R7: A NaN has exponent bits 62:52 all set and a nonzero fraction. It is signaling when bit 51 is clear and quiet when bit 51 is set. In the class mask, bit 8 marks a signaling NaN and bit 9 marks a quiet NaN.
- R8: Classify (op code 3) sets exactly one mask bit. From bit 0 to bit 7 the bits are: -inf, -normal, -subnormal, -0, +0, +subnormal, +normal, +inf. Its invalid flag is 0.
- R9: Result and flag are registered when in_valid is high and hold their value when it is low. out_valid equals in_valid from the previous clock. A synchronous reset clears out_valid, result and flag.
- R10: A boolean result appears in bit 0 with bits 63:1 zero. The class mask appears in bits 9:0 with bits 63:10 zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and op code are valid this cycle |
| op | input | 2 | 0 less-than, 1 equality, 2 maximum, 3 classify |
| opa | input | 64 | Operand A bit pattern |
| opb | input | 64 | Operand B bit pattern |
| out_valid | output | 1 | Registered result is valid |
| result | output | 64 | Registered result word |
| invalid | output | 1 | Registered invalid-operation flag |

## Verification
Some properties are checked by assertions on every clock edge: output valid timing, holding the result while idle, NaN forcing false comparisons, the equality flag raised on any NaN, maximum always returning one of its two operands, symmetry of equality, and a single class bit set for each decoded operand. Other properties can only be shown by the bench's scenarios against its table of expected words: the exact ordering of values with equal and differing signs, zero-sign equivalence, which operand maximum chooses for signed zeros and NaNs, the position of each class bit, and the difference between quiet and signaling flag rules.

// File: rtl/fpcc_pkg.sv
package fpcc_pkg;

  typedef enum logic [1:0] {
    OP_LT    = 2'd0,
    OP_EQ    = 2'd1,
    OP_MAX   = 2'd2,
    OP_CLASS = 2'd3
  } fpcc_op_e;

  // per-operand field decode, one flag per category
  typedef struct packed {
    logic sign;
    logic zero;
    logic sub;
    logic normal;
    logic inf;
    logic nan;
    logic snan;
  } fp_attr_t;

  localparam int CLASS_W = 10;

endpackage

// File: rtl/fpcc_decode.sv
module fpcc_decode
  import fpcc_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W:0] val,
  output fp_attr_t              attr
);
  localparam int W = 1 + EXP_W + FRAC_W;

  logic [EXP_W-1:0]  expo;
  logic [FRAC_W-1:0] frac;
  logic exp_ones, exp_none, frac_none;

  assign expo      = val[W-2 -: EXP_W];
  assign frac      = val[FRAC_W-1:0];
  assign exp_ones  = &expo;
  assign exp_none  = ~|expo;
  assign frac_none = ~|frac;

  always_comb begin
    attr.sign   = val[W-1];
    attr.zero   = exp_none & frac_none;
    attr.sub    = exp_none & ~frac_none;
    attr.normal = ~exp_ones & ~exp_none;
    attr.inf    = exp_ones & frac_none;
    attr.nan    = exp_ones & ~frac_none;
    // top fraction bit clear marks the signaling kind
    attr.snan   = exp_ones & ~frac_none & ~frac[FRAC_W-1];
  end

endmodule

// File: rtl/fpcc_class.sv
module fpcc_class
  import fpcc_pkg::*;
(
  input  fp_attr_t             attr,
  output logic [CLASS_W-1:0]   mask
);
  always_comb begin
    mask    = '0;
    mask[0] =  attr.sign & attr.inf;
    mask[1] =  attr.sign & attr.normal;
    mask[2] =  attr.sign & attr.sub;
    mask[3] =  attr.sign & attr.zero;
    mask[4] = ~attr.sign & attr.zero;
    mask[5] = ~attr.sign & attr.sub;
    mask[6] = ~attr.sign & attr.normal;
    mask[7] = ~attr.sign & attr.inf;
    mask[8] =  attr.snan;
    mask[9] =  attr.nan & ~attr.snan;
  end
endmodule

// File: rtl/fpcc_order.sv
module fpcc_order #(
  parameter int W = 64
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         nan_a,
  input  logic         nan_b,
  input  logic         zero_a,
  input  logic         zero_b,
  output logic         lt,
  output logic         eq
);
  localparam logic [W-1:0] MAG_MASK = {1'b0, {(W-1){1'b1}}};

  // ordering of two non-NaN patterns, true when a sorts below b
  function automatic logic pattern_below(input logic [W-1:0] x, input logic [W-1:0] y);
    logic sx, sy;
    sx = x[W-1];
    sy = y[W-1];
    if (sx != sy)
      return sx && (((x | y) & MAG_MASK) != '0);
    else
      return (x != y) && (sx ^ (x < y));
  endfunction

  logic any_nan;
  assign any_nan = nan_a | nan_b;

  assign lt = ~any_nan & pattern_below(a, b);
  assign eq = ~any_nan & ((a == b) | (zero_a & zero_b));

endmodule

// File: rtl/fpcc_unit.sv
module fpcc_unit
  import fpcc_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [1:0]                op,
  input  logic [EXP_W+FRAC_W:0]     opa,
  input  logic [EXP_W+FRAC_W:0]     opb,
  output logic                      out_valid,
  output logic [EXP_W+FRAC_W:0]     result,
  output logic                      invalid
);
  localparam int W      = 1 + EXP_W + FRAC_W;
  localparam int N_OPND = 2;

  logic [W-1:0]       opnd  [N_OPND];
  fp_attr_t           attr  [N_OPND];
  logic [CLASS_W-1:0] cmask [N_OPND];

  assign opnd[0] = opa;
  assign opnd[1] = opb;

  for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
    fpcc_decode #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_dec (
      .val  (opnd[g]),
      .attr (attr[g])
    );
    fpcc_class u_cls (
      .attr (attr[g]),
      .mask (cmask[g])
    );
    AST_CLASS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      $countones(cmask[g]) == 1); // R8
  end

  // named events for checking
  logic nan_any, snan_any;
  logic lt_ab, eq_ab, lt_ba, eq_ba;
  logic max_take_a;

  assign nan_any  = attr[0].nan  | attr[1].nan;
  assign snan_any = attr[0].snan | attr[1].snan;

  fpcc_order #(.W(W)) u_ord_ab (
    .a(opa), .b(opb),
    .nan_a(attr[0].nan), .nan_b(attr[1].nan),
    .zero_a(attr[0].zero), .zero_b(attr[1].zero),
    .lt(lt_ab), .eq(eq_ab)
  );

  fpcc_order #(.W(W)) u_ord_ba (
    .a(opb), .b(opa),
    .nan_a(attr[1].nan), .nan_b(attr[0].nan),
    .zero_a(attr[1].zero), .zero_b(attr[0].zero),
    .lt(lt_ba), .eq(eq_ba)
  );

  assign max_take_a = attr[1].nan | lt_ba;

  logic [W-1:0] res_nx;
  logic         inv_nx;

  always_comb begin
    res_nx = '0;
    inv_nx = 1'b0;
    unique case (fpcc_op_e'(op))
      OP_LT: begin
        res_nx[0] = lt_ab;
        inv_nx    = snan_any;
      end
      OP_EQ: begin
        res_nx[0] = eq_ab;
        inv_nx    = nan_any;
      end
      OP_MAX: begin
        res_nx = max_take_a ? opa : opb;
        inv_nx = snan_any;
      end
      OP_CLASS: begin
        res_nx[CLASS_W-1:0] = cmask[0];
        inv_nx              = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      invalid   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= res_nx;
        invalid <= inv_nx;
      end
    end
  end

  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> out_valid == $past(in_valid)); // R9

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(in_valid)) |-> ($stable(result) && $stable(invalid))); // R9

  AST_LT_NAN_FALSE: assert property (@(posedge clk) disable iff (rst)
    ($past(in_valid) && !$past(rst) && $past(op) == OP_LT && $past(nan_any))
      |-> result == '0); // R1

  AST_EQ_NAN_INVALID: assert property (@(posedge clk) disable iff (rst)
    ($past(in_valid) && !$past(rst) && $past(op) == OP_EQ && $past(nan_any))
      |-> (invalid && result == '0)); // R2

  AST_EQ_SYMMETRIC: assert property (@(posedge clk) disable iff (rst)
    eq_ab == eq_ba); // R3

  AST_MAX_IS_OPERAND: assert property (@(posedge clk) disable iff (rst)
    ($past(in_valid) && !$past(rst) && $past(op) == OP_MAX)
      |-> (result == $past(opa) || result == $past(opb))); // R6

  AST_CLASS_ZERO_EXT: assert property (@(posedge clk) disable iff (rst)
    ($past(in_valid) && !$past(rst) && $past(op) == OP_CLASS)
      |-> (result[W-1:CLASS_W] == '0 && !invalid)); // R10

endmodule

// File: tb/fpcc_unit_bench.sv
module fpcc_unit_bench;

  localparam logic [63:0] PZ   = 64'h0000000000000000;
  localparam logic [63:0] NZ   = 64'h8000000000000000;
  localparam logic [63:0] ONE  = 64'h3FF0000000000000;
  localparam logic [63:0] NONE = 64'hBFF0000000000000;
  localparam logic [63:0] TWO  = 64'h4000000000000000;
  localparam logic [63:0] PINF = 64'h7FF0000000000000;
  localparam logic [63:0] NINF = 64'hFFF0000000000000;
  localparam logic [63:0] QNAN = 64'h7FF8000000000000;
  localparam logic [63:0] SNAN = 64'h7FF0000000000001;
  localparam logic [63:0] PSUB = 64'h0000000000000001;
  localparam logic [63:0] NSUB = 64'h8000000000000001;

  // {tag[3:0], op[1:0], a, b, expected result, expected invalid}
  localparam int NV = 32;
  localparam logic [198:0] VEC [NV] = '{
    {4'd10, 2'd0, ONE,  TWO,  64'd1, 1'b0},  // R10 R5
    {4'd5,  2'd0, TWO,  ONE,  64'd0, 1'b0},  // R5
    {4'd4,  2'd0, NONE, ONE,  64'd1, 1'b0},  // R4
    {4'd4,  2'd0, NZ,   PZ,   64'd0, 1'b0},  // R4 zeros
    {4'd4,  2'd0, PZ,   NZ,   64'd0, 1'b0},  // R4
    {4'd5,  2'd0, NONE, NINF, 64'd0, 1'b0},  // R5 negatives
    {4'd5,  2'd0, NINF, NONE, 64'd1, 1'b0},  // R5
    {4'd1,  2'd0, QNAN, ONE,  64'd0, 1'b0},  // R1 quiet
    {4'd1,  2'd0, ONE,  SNAN, 64'd0, 1'b1},  // R1 signaling
    {4'd3,  2'd1, PZ,   NZ,   64'd1, 1'b0},  // R3
    {4'd3,  2'd1, ONE,  ONE,  64'd1, 1'b0},  // R3
    {4'd3,  2'd1, ONE,  TWO,  64'd0, 1'b0},  // R3
    {4'd2,  2'd1, QNAN, QNAN, 64'd0, 1'b1},  // R2
    {4'd2,  2'd1, SNAN, ONE,  64'd0, 1'b1},  // R2
    {4'd6,  2'd2, ONE,  TWO,  TWO,   1'b0},  // R6
    {4'd6,  2'd2, NONE, ONE,  ONE,   1'b0},  // R6
    {4'd6,  2'd2, ONE,  QNAN, ONE,   1'b0},  // R6
    {4'd6,  2'd2, QNAN, ONE,  ONE,   1'b0},  // R6
    {4'd6,  2'd2, SNAN, ONE,  ONE,   1'b1},  // R6
    {4'd6,  2'd2, PZ,   NZ,   NZ,    1'b0},  // R6
    {4'd6,  2'd2, NZ,   PZ,   PZ,    1'b0},  // R6
    {4'd6,  2'd2, TWO,  ONE,  TWO,   1'b0},  // R6
    {4'd8,  2'd3, NINF, PZ,   64'h001, 1'b0}, // R8
    {4'd8,  2'd3, NONE, PZ,   64'h002, 1'b0}, // R8
    {4'd8,  2'd3, NSUB, PZ,   64'h004, 1'b0}, // R8
    {4'd8,  2'd3, NZ,   PZ,   64'h008, 1'b0}, // R8
    {4'd8,  2'd3, PZ,   PZ,   64'h010, 1'b0}, // R8
    {4'd8,  2'd3, PSUB, PZ,   64'h020, 1'b0}, // R8
    {4'd8,  2'd3, ONE,  PZ,   64'h040, 1'b0}, // R8
    {4'd8,  2'd3, PINF, PZ,   64'h080, 1'b0}, // R8
    {4'd7,  2'd3, SNAN, PZ,   64'h100, 1'b0}, // R7
    {4'd7,  2'd3, QNAN, PZ,   64'h200, 1'b0}  // R7
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  op = 2'd0;
  logic [63:0] opa = '0;
  logic [63:0] opb = '0;
  logic        out_valid;
  logic [63:0] result;
  logic        invalid;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fpcc_unit u_fpcc_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
    .opa(opa), .opb(opb),
    .out_valid(out_valid), .result(result), .invalid(invalid)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state, R9
    check("R9 reset out_valid", {63'd0, out_valid}, 64'd0);
    check("R9 reset result", result, 64'd0);
    check("R9 reset invalid", {63'd0, invalid}, 64'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      in_valid = 1'b1;
      op  = VEC[i][194:193];
      opa = VEC[i][192:129];
      opb = VEC[i][128:65];
      @(negedge clk);
      check($sformatf("R%0d vec%0d out_valid", VEC[i][198:195], i), {63'd0, out_valid}, 64'd1);
      check($sformatf("R%0d vec%0d result", VEC[i][198:195], i), result, VEC[i][64:1]);
      check($sformatf("R%0d vec%0d invalid", VEC[i][198:195], i), {63'd0, invalid}, {63'd0, VEC[i][0]});
    end

    // idle cycles hold the last result (class of quiet NaN), R9
    in_valid = 1'b0;
    op  = 2'd0;
    opa = ONE;
    opb = TWO;
    @(negedge clk);
    check("R9 idle out_valid", {63'd0, out_valid}, 64'd0);
    check("R9 idle result held", result, 64'h200);
    @(negedge clk);
    check("R9 idle second cycle", result, 64'h200);

    // signaling NaN in B for equality with A NaN-free, R2
    in_valid = 1'b1;
    op  = 2'd1;
    opa = PZ;
    opb = SNAN;
    @(negedge clk);
    check("R2 eq snan result", result, 64'd0);
    check("R2 eq snan invalid", {63'd0, invalid}, 64'd1);

    // max with both NaN keeps A and flags the signaling one, R6
    op  = 2'd2;
    opa = QNAN;
    opb = SNAN;
    @(negedge clk);
    check("R6 max both nan", result, QNAN);
    check("R6 max both nan invalid", {63'd0, invalid}, 64'd1);

    // reset while valid clears the outputs, R9
    rst = 1'b1;
    @(negedge clk);
    check("R9 reset clears valid", {63'd0, out_valid}, 64'd0);
    check("R9 reset clears result", result, 64'd0);
    rst = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    check("R9 valid after reset idle", {63'd0, out_valid}, 64'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule